// File: doc/BRIEF.md
# Completion Interrupt Coalescing Unit

This block sits beside one work queue and decides when software should be interrupted about finished work. Each finished item arrives as a one-cycle pulse carrying a flag that says whether the item wants to be reported. Flagged items raise a pending count. An interrupt level is raised once enough items are pending or once a hold-off timer has run long enough. Software reads the pending count, handles that many results, and writes the handled number back as an acknowledge. The acknowledge lowers the count and restarts the timer.

The hold-off timer stays at zero while nothing is pending. It advances by one every clock cycle while the count is nonzero, and it stops at its maximum value instead of wrapping. The programmed time threshold is scaled by 1024 cycles. The decision is made again on every cycle, including the cycle of an acknowledge. If a completion lands in the same cycle as the acknowledge, it is therefore never lost.

A three-state machine holds the decision:
- ST_EMPTY: nothing is pending.
- ST_HOLD: items are pending, but no threshold has been met yet.
- ST_FIRE: a threshold has been met.

Its transitions are:
- fill: ST_EMPTY to ST_HOLD.
- burst: ST_EMPTY to ST_FIRE.
- trip: ST_HOLD to ST_FIRE.
- relax: ST_FIRE to ST_HOLD, after an acknowledge or a direct write.
- drain: any state to ST_EMPTY.
- stay: no change.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, `pending_o` is 0 and `irq_o` is 0. Both thresholds reset to 0 and the enable resets to 0.
- R2: An edge with `done_pulse_i`=1 and `done_req_i`=1 raises `pending_o` by exactly one. A pulse with `done_req_i`=0 leaves the count unchanged.
- R3: With the enable set, `irq_o` is 1 in the cycle after the edge at which `pending_o` becomes at least the message threshold.
- R4: A message threshold of 0 acts exactly as a threshold of 1.
- R5: With time threshold T not 0, `irq_o` rises 1024*T edges after the edge at which `pending_o` left 0. One edge earlier it is still 0.
- R6: A time threshold of 0 disables the time trigger. A single pending item below the message threshold never raises `irq_o`.
- R7: An acknowledge subtracts `ack_val_i` from the count and restarts the timer at 0. The trigger is decided again from the new count at that same edge, so `irq_o` stays 1 if the remainder still meets the message threshold.
- R8: An acknowledge larger than the pending count leaves the count at 0. While the count is 0, `irq_o` is 0.
- R9: A flagged completion and an acknowledge at the same edge give the old count plus one minus the acknowledge value.
- R10: With the enable clear, `irq_o` stays 0, but counting and timing continue. Setting the enable shows a met condition at the same edge.
- R11: A direct count write loads `cnt_val_i` and restarts the timer. It overrides a completion or an acknowledge at the same edge.
- R12: The count stops at 2^CNT_W-1. A further flagged completion leaves it there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_pulse_i | input | 1 | One item finished this cycle |
| done_req_i | input | 1 | Finished item asks to be reported |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_val_i | input | CNT_W | Number of items acknowledged |
| cnt_we_i | input | 1 | Diagnostic direct count write strobe |
| cnt_val_i | input | CNT_W | Value for the direct count write |
| msg_we_i | input | 1 | Message threshold write strobe |
| msg_val_i | input | CNT_W | Message threshold value |
| time_we_i | input | 1 | Time threshold write strobe |
| time_val_i | input | TIME_W | Time threshold, in units of 1024 cycles |
| en_we_i | input | 1 | Interrupt enable write strobe |
| en_val_i | input | 1 | Interrupt enable value |
| pending_o | output | CNT_W | Current pending count |
| irq_o | output | 1 | Interrupt level |

## Verification
The assertions assume that a count write stands alone as the strongest update of its cycle. They also assume that the strobes are never X after reset. The bench drives every strobe low except for the single cycle in which it is meant to act. The saturation property assumes that no acknowledge or direct write arrives while the count is held at its maximum. The stimulus reaches the maximum only through a direct write and leaves it only through a single acknowledge.

// File: rtl/coal_pkg.sv
package coal_pkg;
    // Trigger decision states of the coalescing unit
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FIRE  = 2'd2
    } coal_state_e;
endpackage

// File: rtl/coal_count.sv
module coal_count #(
    parameter int CNT_W = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bump_i,
    input  logic             ack_we_i,
    input  logic [CNT_W-1:0] ack_val_i,
    input  logic             wr_we_i,
    input  logic [CNT_W-1:0] wr_val_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             restart_o
);
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] with_bump;
    logic [CNT_W:0] after_ack;

    // Completion first, then acknowledge (clamped at zero), then saturation
    always_comb begin
        with_bump = {1'b0, cnt_q_o} + {{CNT_W{1'b0}}, bump_i};
        after_ack = with_bump;
        if (ack_we_i) begin
            if (with_bump >= {1'b0, ack_val_i}) begin
                after_ack = with_bump - {1'b0, ack_val_i};
            end else begin
                after_ack = '0;
            end
        end
        if (wr_we_i) begin
            cnt_d_o = wr_val_i;
        end else if (after_ack > CNT_MAX) begin
            cnt_d_o = CNT_MAX[CNT_W-1:0];
        end else begin
            cnt_d_o = after_ack[CNT_W-1:0];
        end
    end

    assign restart_o = ack_we_i | wr_we_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q_o <= '0;
        end else begin
            cnt_q_o <= cnt_d_o;
        end
    end
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
    parameter int TIME_W     = 16,
    parameter int SCALE_LOG2 = 10,
    localparam int TMR_W     = TIME_W + SCALE_LOG2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             cur_nz_i,
    input  logic             nxt_nz_i,
    output logic [TMR_W-1:0] tmr_q_o,
    output logic [TMR_W-1:0] tmr_d_o
);
    localparam logic [TMR_W-1:0] TMR_TOP = {TMR_W{1'b1}};

    // Held at zero while empty, restarted on acknowledge, saturating otherwise
    always_comb begin
        if (restart_i || !cur_nz_i || !nxt_nz_i) begin
            tmr_d_o = '0;
        end else if (tmr_q_o == TMR_TOP) begin
            tmr_d_o = tmr_q_o;
        end else begin
            tmr_d_o = tmr_q_o + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q_o <= '0;
        end else begin
            tmr_q_o <= tmr_d_o;
        end
    end
endmodule

// File: rtl/coal_trigger.sv
module coal_trigger
    import coal_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int TIME_W     = 16,
    parameter int SCALE_LOG2 = 10,
    localparam int TMR_W     = TIME_W + SCALE_LOG2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CNT_W-1:0]  cnt_d_i,
    input  logic [TMR_W-1:0]  tmr_d_i,
    input  logic              msg_we_i,
    input  logic [CNT_W-1:0]  msg_val_i,
    input  logic              time_we_i,
    input  logic [TIME_W-1:0] time_val_i,
    input  logic              en_we_i,
    input  logic              en_val_i,
    output logic [CNT_W-1:0]  msg_thr_o,
    output logic              en_o,
    output logic              irq_o
);
    localparam logic [CNT_W-1:0] THR_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    coal_state_e       state_q, state_d;
    logic [CNT_W-1:0]  msg_q, msg_d, eff_thr;
    logic [TIME_W-1:0] time_q, time_d;
    logic              en_q, en_d;
    logic              nz, count_hit, time_hit, meet;

    always_comb begin
        msg_d     = msg_we_i  ? msg_val_i  : msg_q;
        time_d    = time_we_i ? time_val_i : time_q;
        en_d      = en_we_i   ? en_val_i   : en_q;
        eff_thr   = (msg_d == '0) ? THR_ONE : msg_d;
        nz        = (cnt_d_i != '0);
        count_hit = (cnt_d_i >= eff_thr);
        time_hit  = (time_d != '0) && (tmr_d_i >= {time_d, {SCALE_LOG2{1'b0}}});
        meet      = nz && (count_hit || time_hit);
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (meet)    state_d = ST_FIRE;   // burst
                else if (nz) state_d = ST_HOLD;   // fill
            end
            ST_HOLD: begin
                if (!nz)       state_d = ST_EMPTY; // drain
                else if (meet) state_d = ST_FIRE;  // trip
            end
            ST_FIRE: begin
                if (!nz)        state_d = ST_EMPTY; // drain
                else if (!meet) state_d = ST_HOLD;  // relax
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State and configuration registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_EMPTY;
            msg_q   <= '0;
            time_q  <= '0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            msg_q   <= msg_d;
            time_q  <= time_d;
            en_q    <= en_d;
        end
    end

    // Outputs
    always_comb begin
        irq_o     = en_q && (state_q == ST_FIRE);
        msg_thr_o = msg_q;
        en_o      = en_q;
    end
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
    parameter int CNT_W      = 20,
    parameter int TIME_W     = 16,
    parameter int SCALE_LOG2 = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              done_pulse_i,
    input  logic              done_req_i,
    input  logic              ack_we_i,
    input  logic [CNT_W-1:0]  ack_val_i,
    input  logic              cnt_we_i,
    input  logic [CNT_W-1:0]  cnt_val_i,
    input  logic              msg_we_i,
    input  logic [CNT_W-1:0]  msg_val_i,
    input  logic              time_we_i,
    input  logic [TIME_W-1:0] time_val_i,
    input  logic              en_we_i,
    input  logic              en_val_i,
    output logic [CNT_W-1:0]  pending_o,
    output logic              irq_o
);
    localparam int TMR_W = TIME_W + SCALE_LOG2;

    logic [CNT_W-1:0] cnt_q, cnt_d, msg_thr_q;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic             restart, en_q;

    coal_count #(.CNT_W(CNT_W)) count_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .bump_i    (done_pulse_i & done_req_i),
        .ack_we_i  (ack_we_i),
        .ack_val_i (ack_val_i),
        .wr_we_i   (cnt_we_i),
        .wr_val_i  (cnt_val_i),
        .cnt_q_o   (cnt_q),
        .cnt_d_o   (cnt_d),
        .restart_o (restart)
    );

    coal_timer #(.TIME_W(TIME_W), .SCALE_LOG2(SCALE_LOG2)) timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .cur_nz_i  (cnt_q != '0),
        .nxt_nz_i  (cnt_d != '0),
        .tmr_q_o   (tmr_q),
        .tmr_d_o   (tmr_d)
    );

    coal_trigger #(.CNT_W(CNT_W), .TIME_W(TIME_W), .SCALE_LOG2(SCALE_LOG2)) trig_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cnt_d_i    (cnt_d),
        .tmr_d_i    (tmr_d),
        .msg_we_i   (msg_we_i),
        .msg_val_i  (msg_val_i),
        .time_we_i  (time_we_i),
        .time_val_i (time_val_i),
        .en_we_i    (en_we_i),
        .en_val_i   (en_val_i),
        .msg_thr_o  (msg_thr_q),
        .en_o       (en_q),
        .irq_o      (irq_o)
    );

    assign pending_o = cnt_q;
endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             bump_i,
    input logic             ack_we_i,
    input logic [CNT_W-1:0] ack_val_i,
    input logic             wr_we_i,
    input logic [CNT_W-1:0] wr_val_i,
    input logic [CNT_W-1:0] pending_i,
    input logic [CNT_W-1:0] msg_thr_i,
    input logic             en_i,
    input logic             irq_i
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    logic [CNT_W-1:0] eff;
    assign eff = (msg_thr_i == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : msg_thr_i;

    // R8
    empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_i == '0) |-> !irq_i);
    // R2
    step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bump_i && !ack_we_i && !wr_we_i && pending_i != CMAX) |=> (pending_i == $past(pending_i) + 1'b1));
    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bump_i && !ack_we_i && !wr_we_i) |=> $stable(pending_i));
    // R3
    count_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && pending_i != '0 && pending_i >= eff) |-> irq_i);
    // R10
    gate_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> !irq_i);
    // R8
    ack_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_we_i && !wr_we_i && !bump_i && ack_val_i >= pending_i) |=> (pending_i == '0));
    // R11
    direct_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_we_i |=> (pending_i == $past(wr_val_i)));
    // R12
    top_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_i == CMAX && !ack_we_i && !wr_we_i) |=> (pending_i == CMAX));
endmodule

bind irq_coalesce coal_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bump_i    (done_pulse_i & done_req_i),
    .ack_we_i  (ack_we_i),
    .ack_val_i (ack_val_i),
    .wr_we_i   (cnt_we_i),
    .wr_val_i  (cnt_val_i),
    .pending_i (pending_o),
    .msg_thr_i (msg_thr_q),
    .en_i      (en_q),
    .irq_i     (irq_o)
);

// File: tb/irq_coalesce_tb_top.sv
`timescale 1ns/1ps
module irq_coalesce_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_pulse = 1'b0, done_req = 1'b0;
    logic        ack_we = 1'b0, cnt_we = 1'b0;
    logic [19:0] ack_val = '0, cnt_val = '0;
    logic        msg_we = 1'b0, time_we = 1'b0, en_we = 1'b0, en_val = 1'b0;
    logic [19:0] msg_val = '0;
    logic [15:0] time_val = '0;
    logic [19:0] pending;
    logic        irq;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    logic [19:0] ep_q[$];
    logic        ei_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    irq_coalesce dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .done_pulse_i(done_pulse), .done_req_i(done_req),
        .ack_we_i(ack_we), .ack_val_i(ack_val),
        .cnt_we_i(cnt_we), .cnt_val_i(cnt_val),
        .msg_we_i(msg_we), .msg_val_i(msg_val),
        .time_we_i(time_we), .time_val_i(time_val),
        .en_we_i(en_we), .en_val_i(en_val),
        .pending_o(pending), .irq_o(irq)
    );

    // Driver: applies one cycle of stimulus at the falling edge, pushes the
    // expected state after the next rising edge when asked to.
    task automatic drv(input logic d, input logic r, input logic aw, input logic [19:0] av,
                       input logic cw, input logic [19:0] cv, input logic chk,
                       input logic [19:0] ep, input logic ei, input string tag);
        @(negedge clk);
        done_pulse = d; done_req = r; ack_we = aw; ack_val = av;
        cnt_we = cw; cnt_val = cv; msg_we = 1'b0; time_we = 1'b0; en_we = 1'b0;
        if (chk) begin
            ep_q.push_back(ep); ei_q.push_back(ei); tag_q.push_back(tag);
        end
    endtask

    task automatic cfg(input logic mw, input logic [19:0] mv, input logic tw,
                       input logic [15:0] tv, input logic ew, input logic ev);
        @(negedge clk);
        done_pulse = 1'b0; done_req = 1'b0; ack_we = 1'b0; cnt_we = 1'b0;
        msg_we = mw; msg_val = mv; time_we = tw; time_val = tv; en_we = ew; en_val = ev;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(0, 0, 0, '0, 0, '0, 0, '0, 0, "");
    endtask

    task automatic comp(input logic [19:0] ep, input logic ei, input string tag);
        drv(1, 1, 0, '0, 0, '0, 1, ep, ei, tag);
    endtask

    task automatic ack(input logic [19:0] v, input logic [19:0] ep, input logic ei, input string tag);
        drv(0, 0, 1, v, 0, '0, 1, ep, ei, tag);
    endtask

    task automatic look(input logic [19:0] ep, input logic ei, input string tag);
        drv(0, 0, 0, '0, 0, '0, 1, ep, ei, tag);
    endtask

    // Monitor: compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (ep_q.size() > 0) begin
                logic [19:0] ep;
                logic        ei;
                string       tg;
                ep = ep_q.pop_front(); ei = ei_q.pop_front(); tg = tag_q.pop_front();
                checks++;
                if (pending !== ep || irq !== ei) begin
                    fails++;
                    $display("FAIL %s: pending=%0h irq=%0b expected pending=%0h irq=%0b",
                             tg, pending, irq, ep, ei);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        look(20'd0, 1'b0, "R1 reset state");

        cfg(1, 20'd4, 1, 16'd0, 1, 1'b1);
        drv(1, 0, 0, '0, 0, '0, 1, 20'd0, 1'b0, "R2 unflagged completion ignored");
        comp(20'd1, 1'b0, "R2 first flagged completion");
        comp(20'd2, 1'b0, "R2 second completion");
        comp(20'd3, 1'b0, "R3 below threshold");
        comp(20'd4, 1'b1, "R3 threshold reached");

        ack(20'd1, 20'd3, 1'b0, "R7 ack drops below threshold");
        drv(1, 1, 1, 20'd1, 0, '0, 1, 20'd3, 1'b0, "R9 completion with ack");
        comp(20'd4, 1'b1, "R3 refire");
        cfg(1, 20'd2, 0, 16'd0, 0, 1'b0);
        ack(20'd2, 20'd2, 1'b1, "R7 reassert after ack");
        ack(20'd5, 20'd0, 1'b0, "R8 oversized ack clamps");

        cfg(1, 20'd0, 0, 16'd0, 0, 1'b0);
        comp(20'd1, 1'b1, "R4 zero threshold acts as one");
        ack(20'd1, 20'd0, 1'b0, "R8 drained");

        cfg(0, '0, 0, 16'd0, 1, 1'b0);
        comp(20'd1, 1'b0, "R10 disabled output low");
        comp(20'd2, 1'b0, "R10 counting continues");
        cfg(0, '0, 0, 16'd0, 1, 1'b1);
        look(20'd2, 1'b1, "R10 enable shows met condition");
        ack(20'd2, 20'd0, 1'b0, "R8 drained again");

        cfg(1, 20'd100, 0, 16'd0, 0, 1'b0);
        comp(20'd1, 1'b0, "R6 one pending");
        idle(3000);
        look(20'd1, 1'b0, "R6 no time trigger when disabled");
        ack(20'd1, 20'd0, 1'b0, "R8 drained");

        cfg(0, '0, 1, 16'd1, 0, 1'b0);
        comp(20'd1, 1'b0, "R5 timer start");
        idle(1022);
        look(20'd1, 1'b0, "R5 one edge before time limit");
        look(20'd1, 1'b1, "R5 time limit reached");

        drv(1, 1, 1, 20'd1, 0, '0, 1, 20'd1, 1'b0, "R7 ack restarts timer");
        idle(1022);
        look(20'd1, 1'b0, "R7 restarted timer short");
        look(20'd1, 1'b1, "R7 restarted timer expires");

        drv(1, 1, 1, 20'd3, 1, 20'd7, 1, 20'd7, 1'b0, "R11 direct write wins");
        idle(1022);
        look(20'd7, 1'b0, "R11 timer restarted by write");
        look(20'd7, 1'b1, "R11 timer expires after write");

        drv(0, 0, 0, '0, 1, 20'hFFFFF, 1, 20'hFFFFF, 1'b1, "R11 load maximum");
        comp(20'hFFFFF, 1'b1, "R12 count saturates");
        ack(20'hFFFFF, 20'd0, 1'b0, "R8 full drain");

        idle(2);
        wait (ep_q.size() == 0);
        #40;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule